// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block gates a bank of clock outputs that are all in phase with the processor clock. It follows an active-low power-down pin, and it never cuts a pulse short. The raw pin first passes through a two-stage synchronizer. A qualifier then acts only on a level that holds for two consecutive rising edges. The per-output gates change state only on the falling edge of the clock. As a result every output either completes its high phase or does not start one.

Each output also has an enable bit from a configuration register. A disabled output is parked low and its driver stays on. A 3-bit mode code turns off every output driver at once. Code 000 means high impedance. Any other code means drive.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every `clk_out` bit stays low and every `clk_oe` bit is low from that edge on.
- R2: A low level on `pd_n_raw` is ignored if the synchronized samples do not read low on two consecutive rising edges. This covers a low seen at a single edge, and lows at edges that are separated by a high.
- R3: Let E be the first rising edge that samples `pd_n_raw` low, with the pin held low after that. The outputs still pulse in the high phases that start at edges E through E+3. From edge E+4 onward they stay low.
- R4: Every high pulse on any `clk_out` bit lasts a full half period of `clk`, including pulses around power-down entry and exit. Stopped outputs keep `clk_oe` high.
- R5: Let E be the first rising edge that samples `pd_n_raw` high after a stop, with the pin held high after that. The outputs stay low through edge E+3. Their first pulse starts at edge E+4.
- R6: Bit i of `clk_en` controls `clk_out[i]`, where 1 enables and 0 disables. A change made after edge E applies from the high phase that starts at E+1. A disabled output is held low and its `clk_oe` bit stays high.
- R7: If `mode_sel` is 3'b000 at a rising edge, `clk_oe` is all zeros after that edge. Any other code gives all ones.
- R8: While the outputs are stopped by power-down, changing `clk_en` has no effect, and setting bits back to 1 restarts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; source of all gated outputs |
| rst | input | 1 | Synchronous active-high reset |
| pd_n_raw | input | 1 | Asynchronous active-low power-down pin |
| clk_en | input | NUM_OUT | Per-output enable bits from configuration |
| mode_sel | input | 3 | Mode code; 000 turns all drivers off |
| clk_out | output | NUM_OUT | Gated clock outputs |
| clk_oe | output | NUM_OUT | Output-driver enables for the gated clocks |

## Verification
The bench measures the width of every output pulse against half a clock period. A gate that switched while the clock was high would show up as a short pulse at power-down entry, at exit, or at an enable change. It counts edges exactly on entry and exit. A qualifier that acted on one sample, or a synchronizer that was too short or too long, would move the last or first pulse by at least one cycle. Single-edge lows and alternating lows check that a qualifier which forgets to restart its count would stop the clocks by mistake. Toggling the enables while stopped catches an enable path that bypasses the power-down gate.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic {
    ST_HALT = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;

  localparam logic [2:0] MODE_HIZ = 3'b000;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= RST_VAL;
          else     chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= RST_VAL;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cs_qualify.sv
module cs_qualify
  import clkstop_pkg::*;
#(
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic smp,
  output logic run
);
  localparam int CW = (QUAL > 1) ? $clog2(QUAL) : 1;

  run_state_t    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (smp != logic'(state_q)) begin
      if (cnt_q == CW'(QUAL - 1)) begin
        state_q <= run_state_t'(smp);
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign run = (state_q == ST_RUN);

  generate
    if (QUAL >= 2) begin : g_chk
      // R2: a stop needs the two preceding samples both low
      a_r2_stop_needs_two_lows: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> (!$past(smp) && !$past(smp, 2)));
      // R5: a restart needs the two preceding samples both high
      a_r5_restart_needs_two_highs: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> ($past(smp) && $past(smp, 2)));
    end
  endgenerate
endmodule

// File: rtl/cs_gate.sv
module cs_gate #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [NUM_OUT-1:0] en,
  output logic [NUM_OUT-1:0] gate_q
);
  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
      // updated only while clk is low, so pulses are never clipped
      always_ff @(negedge clk) begin
        if (rst) gate_q[i] <= 1'b0;
        else     gate_q[i] <= run & en[i];
      end

      // R6: a cleared enable parks its output at the next low phase
      a_r6_disable_forces_low: assert property (@(negedge clk) disable iff (rst)
        !en[i] |=> !gate_q[i]);
      // R8: power-down wins over any enable value
      a_r8_halt_forces_low: assert property (@(negedge clk) disable iff (rst)
        !run |=> !gate_q[i]);
    end
  endgenerate
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NUM_OUT   = 4,
  parameter int SYNC_LEN  = 2,
  parameter int QUAL_CNT  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pd_n_raw,
  input  logic [NUM_OUT-1:0] clk_en,
  input  logic [2:0]         mode_sel,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_oe
);
  logic pd_n_sync;
  logic run;
  logic [NUM_OUT-1:0] gate_q;

  cs_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pd_n_raw),
    .q   (pd_n_sync)
  );

  cs_qualify #(.QUAL(QUAL_CNT)) u_qual (
    .clk (clk),
    .rst (rst),
    .smp (pd_n_sync),
    .run (run)
  );

  cs_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .en     (clk_en),
    .gate_q (gate_q)
  );

  assign clk_out = {NUM_OUT{clk}} & gate_q;

  always_ff @(posedge clk) begin
    if (rst)                    clk_oe <= '0;
    else if (mode_sel == MODE_HIZ) clk_oe <= '0;
    else                        clk_oe <= '1;
  end

  // R7: the off code releases every driver after the edge that sees it
  a_r7_hiz_code: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == MODE_HIZ) |=> (clk_oe == '0));
  // R7: any other code drives all outputs
  a_r7_drive_code: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != MODE_HIZ) |=> (clk_oe == '1));
endmodule

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/100ps
module sim_clkstop_ctrl;
  localparam int NB = 4;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_n_raw = 1'b1;
  logic [NB-1:0] clk_en = '1;
  logic [2:0] mode_sel = 3'b001;
  logic [NB-1:0] clk_out;
  logic [NB-1:0] clk_oe;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int            at;
    logic [NB-1:0] out;
    logic [NB-1:0] oe;
    string         tag;
  } exp_t;
  exp_t sb[$];

  clkstop_ctrl #(.NUM_OUT(NB)) u0 (
    .clk(clk), .rst(rst), .pd_n_raw(pd_n_raw), .clk_en(clk_en),
    .mode_sel(mode_sel), .clk_out(clk_out), .clk_oe(clk_oe)
  );

  initial forever #(HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // driver side: push expectations for cycles a..b
  task automatic expect_span(int a, int b, logic [NB-1:0] o, logic [NB-1:0] e, string tag);
    for (int k = a; k <= b; k++) sb.push_back('{at: cyc + k, out: o, oe: e, tag: tag});
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  task automatic drain();
    while (sb.size() > 0) tick(1);
    tick(1);
  endtask

  // monitor: sample mid high phase
  initial forever begin
    @(posedge clk);
    #1.25;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (e.at != cyc || clk_out !== e.out || clk_oe !== e.oe) begin
        bad++;
        $display("FAIL %s cyc=%0d out=%b oe=%b expected out=%b oe=%b (due %0d)",
                 e.tag, cyc, clk_out, clk_oe, e.out, e.oe, e.at);
      end
    end
  end

  // R4: pulse width monitor on every output
  realtime t_rise [NB];
  generate
    for (genvar g = 0; g < NB; g++) begin : g_pw
      always @(posedge clk_out[g]) t_rise[g] = $realtime;
      always @(negedge clk_out[g]) begin
        realtime w;
        w = $realtime - t_rise[g];
        total++;
        if (w < HALF - 0.05 || w > HALF + 0.05) begin
          bad++;
          $display("FAIL R4 bit%0d pulse width=%0.2f expected=%0.2f", g, w, HALF);
        end
      end
    end
  endgenerate

  initial begin
    #(200000 * 2 * HALF);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(1);
    expect_span(1, 2, '0, '0, "R1 reset");
    tick(3);
    rst = 1'b0;
    expect_span(3, 6, '1, '1, "R1 run after reset");
    drain();

    // R2: single low edge
    pd_n_raw = 1'b0;
    expect_span(1, 10, '1, '1, "R2 single low");
    tick(1);
    pd_n_raw = 1'b1;
    drain();
    // R2: lows split by a high
    expect_span(1, 12, '1, '1, "R2 alternating");
    pd_n_raw = 1'b0; tick(1);
    pd_n_raw = 1'b1; tick(1);
    pd_n_raw = 1'b0; tick(1);
    pd_n_raw = 1'b1;
    drain();

    // R3: entry latency, R4 held low with drivers on
    pd_n_raw = 1'b0;
    expect_span(1, 4, '1, '1, "R3 last pulses");
    expect_span(5, 8, '0, '1, "R3 stopped");
    drain();

    // R8: enables ignored while stopped
    clk_en = 4'b0000;
    tick(2);
    clk_en = 4'b1111;
    expect_span(1, 5, '0, '1, "R8 re-enable ignored");
    drain();

    // R5: exit latency
    pd_n_raw = 1'b1;
    expect_span(1, 4, '0, '1, "R5 still stopped");
    expect_span(5, 8, '1, '1, "R5 restarted");
    drain();

    // R6: per-bit enable, disabled held low, drivers on
    clk_en = 4'b1010;
    expect_span(1, 3, 4'b1010, '1, "R6 disable bits 0 and 2");
    drain();
    clk_en = 4'b0101;
    expect_span(1, 3, 4'b0101, '1, "R6 swap bits");
    drain();
    clk_en = 4'b1111;
    expect_span(1, 3, 4'b1111, '1, "R6 re-enable");
    drain();

    // R7: mode code
    mode_sel = 3'b000;
    expect_span(1, 3, '1, '0, "R7 off code");
    drain();
    mode_sel = 3'b101;
    expect_span(1, 3, '1, '1, "R7 drive code");
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule